// File: doc/BRIEF.md
# External Bus Port Multiplexer

This block lets three general-purpose 8-bit ports double as a memory bus. When a control byte selects bus operation, two ports become the sixteen address lines and the third becomes the eight data lines; otherwise every pin simply carries the ordinary port output value and direction enable that arrive as inputs. The CPU side supplies the address, write data, internal read data, a read/not-write flag, an on-chip decode flag and the PHI2 clock phase.

In normal bus operation the pins hide on-chip traffic: for an on-chip access the address and data pins are forced high. A separate emulation bit instead exposes every internal cycle, so an external trace tool sees the real address and the real read or write data. On external cycles the data lines float while PHI2 is low. Writes drive the write data while PHI2 is high. Reads leave the lines floating and capture the pin value into a read register on each clock edge that falls in the PHI2-high part of the read.

Top module: `xbus_port_mux`

## Requirements
- R1: Bus operation is on only when control bit 0 and control bit 7 are both 1; control bits other than 0, 3 and 7 have no effect on any output.
- R2: With bus operation off, address pins carry port values `gp_out[15:0]` and enables `gp_oe[15:0]`, and data pins carry `gp_out[23:16]` and `gp_oe[23:16]`.
- R3: With bus operation on, all sixteen address output enables are 1.
- R4: In normal bus operation (control bit 3 = 0), an on-chip access drives all address pins to 1.
- R5: In normal bus operation, an on-chip access drives all data pins to 1 with all data enables at 1.
- R6: In emulation (control bit 3 = 1), the address pins carry `cpu_addr` for on-chip and external accesses alike.
- R7: In emulation, an on-chip access drives the data pins with `cpu_wdata` when `cpu_rnw` = 0 and with `cpu_rdata_int` when `cpu_rnw` = 1, all enables at 1.
- R8: During an external access with `phi2` = 0, all data enables are 0.
- R9: During an external write with `phi2` = 1, the data pins carry `cpu_wdata` with all enables at 1.
- R10: During an external read, the data enables stay 0. At each clock edge where bus operation is on, the access is an external read and `phi2` = 1, `ext_rdata` loads `data_pin_in`. At other edges it holds its value. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_bits | input | 8 | Bus control byte (bits 0, 3, 7 used) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata_int | input | 8 | Data read from on-chip memory |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| onchip_sel | input | 1 | 1 = access targets on-chip memory |
| phi2 | input | 1 | Bus clock phase, 1 = high phase |
| gp_out | input | 24 | Ordinary port output values, three ports |
| gp_oe | input | 24 | Ordinary port direction enables |
| data_pin_in | input | 8 | Value seen on the data pins |
| addr_pin_out | output | 16 | Address port pin values |
| addr_pin_oe | output | 16 | Address port pin enables |
| data_pin_out | output | 8 | Data port pin values |
| data_pin_oe | output | 8 | Data port pin enables |
| ext_rdata | output | 8 | Captured external read data |

## Verification
The bench builds the block with its defaults: 16 address bits, 8-bit ports and the registered read-capture variant. With these, every control byte that matters is reachable, including ones that set only one of the two enabling bits and ones that pad unused bits. The registered capture puts the hold-while-PHI2-low behaviour and the reset value of the read register within reach. Because both address ports come from the same generate loop, patterns that differ between the high and low address bytes show whether each port is wired to its own slice.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_MASK = 2'd1,
      SRC_LIVE = 2'd2
   } pin_src_e;

   typedef struct packed {
      logic     bus_on;
      logic     emu_on;
      pin_src_e src;
   } mode_t;

endpackage

// File: rtl/xbus_mode_dec.sv
module xbus_mode_dec
   import xbus_pkg::*;
#(
   parameter int CTL_W   = 8,
   parameter int EN_BIT_A = 0,
   parameter int EN_BIT_B = 7,
   parameter int EMU_BIT  = 3
) (
   input  logic [CTL_W-1:0] ctl_bits,
   input  logic             onchip_sel,
   output mode_t            mode
);

   generate
      if (EN_BIT_A >= CTL_W || EN_BIT_B >= CTL_W || EMU_BIT >= CTL_W) begin : g_bad_bits
         $error("xbus_mode_dec: control bit index outside control word");
      end
   endgenerate

   always_comb begin
      mode.bus_on = ctl_bits[EN_BIT_A] & ctl_bits[EN_BIT_B];
      mode.emu_on = ctl_bits[EMU_BIT];
      if (!mode.bus_on) begin
         mode.src = SRC_PORT;
      end else if (onchip_sel && !mode.emu_on) begin
         mode.src = SRC_MASK;
      end else begin
         mode.src = SRC_LIVE;
      end
   end

endmodule

// File: rtl/xbus_addr_lane.sv
module xbus_addr_lane
   import xbus_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  pin_src_e          src,
   input  logic [PORT_W-1:0] addr_slice,
   input  logic [PORT_W-1:0] port_val,
   input  logic [PORT_W-1:0] port_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);

   always_comb begin
      unique case (src)
         SRC_MASK: begin
            pin_out = '1;
            pin_oe  = '1;
         end
         SRC_LIVE: begin
            pin_out = addr_slice;
            pin_oe  = '1;
         end
         default: begin
            pin_out = port_val;
            pin_oe  = port_oe;
         end
      endcase
   end

endmodule

// File: rtl/xbus_data_lane.sv
module xbus_data_lane
   import xbus_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  pin_src_e          src,
   input  logic              onchip_sel,
   input  logic              cpu_rnw,
   input  logic              phi2,
   input  logic [PORT_W-1:0] cpu_wdata,
   input  logic [PORT_W-1:0] cpu_rdata_int,
   input  logic [PORT_W-1:0] port_val,
   input  logic [PORT_W-1:0] port_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);

   logic trace_cycle;
   logic ext_drive;

   assign trace_cycle = onchip_sel;
   assign ext_drive   = phi2 & ~cpu_rnw;

   always_comb begin
      unique case (src)
         SRC_MASK: begin
            pin_out = '1;
            pin_oe  = '1;
         end
         SRC_LIVE: begin
            if (trace_cycle) begin
               pin_out = cpu_rnw ? cpu_rdata_int : cpu_wdata;
               pin_oe  = '1;
            end else begin
               pin_out = cpu_wdata;
               pin_oe  = {PORT_W{ext_drive}};
            end
         end
         default: begin
            pin_out = port_val;
            pin_oe  = port_oe;
         end
      endcase
   end

endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
   parameter int DATA_W      = 8,
   parameter bit CAPTURE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (CAPTURE_REG) begin : g_reg
         logic [DATA_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (take) begin
               hold_q <= pin_in;
            end
         end
         assign rdata = hold_q;
      end else begin : g_pass
         logic unused_take;
         assign unused_take = take;
         assign rdata = pin_in;
      end
   endgenerate

endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
   import xbus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int PORT_W      = 8,
   parameter int CTL_W       = 8,
   parameter int EN_BIT_A    = 0,
   parameter int EN_BIT_B    = 7,
   parameter int EMU_BIT     = 3,
   parameter bit CAPTURE_REG = 1'b1,
   localparam int N_APORT    = ADDR_W / PORT_W,
   localparam int N_PORT     = N_APORT + 1,
   localparam int GP_W       = N_PORT * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_bits,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [PORT_W-1:0] cpu_wdata,
   input  logic [PORT_W-1:0] cpu_rdata_int,
   input  logic              cpu_rnw,
   input  logic              onchip_sel,
   input  logic              phi2,
   input  logic [GP_W-1:0]   gp_out,
   input  logic [GP_W-1:0]   gp_oe,
   input  logic [PORT_W-1:0] data_pin_in,
   output logic [ADDR_W-1:0] addr_pin_out,
   output logic [ADDR_W-1:0] addr_pin_oe,
   output logic [PORT_W-1:0] data_pin_out,
   output logic [PORT_W-1:0] data_pin_oe,
   output logic [PORT_W-1:0] ext_rdata
);

   generate
      if (ADDR_W % PORT_W != 0) begin : g_bad_split
         $error("xbus_port_mux: ADDR_W must be a multiple of PORT_W");
      end
      if (N_APORT < 1) begin : g_no_aport
         $error("xbus_port_mux: at least one address port is needed");
      end
   endgenerate

   mode_t mode;
   logic  take_rd;

   xbus_mode_dec #(
      .CTL_W   (CTL_W),
      .EN_BIT_A(EN_BIT_A),
      .EN_BIT_B(EN_BIT_B),
      .EMU_BIT (EMU_BIT)
   ) u_dec (
      .ctl_bits  (ctl_bits),
      .onchip_sel(onchip_sel),
      .mode      (mode)
   );

   for (genvar p = 0; p < N_APORT; p++) begin : g_aport
      xbus_addr_lane #(.PORT_W(PORT_W)) u_lane (
         .src       (mode.src),
         .addr_slice(cpu_addr[p*PORT_W +: PORT_W]),
         .port_val  (gp_out[p*PORT_W +: PORT_W]),
         .port_oe   (gp_oe[p*PORT_W +: PORT_W]),
         .pin_out   (addr_pin_out[p*PORT_W +: PORT_W]),
         .pin_oe    (addr_pin_oe[p*PORT_W +: PORT_W])
      );
   end

   xbus_data_lane #(.PORT_W(PORT_W)) u_data (
      .src          (mode.src),
      .onchip_sel   (onchip_sel),
      .cpu_rnw      (cpu_rnw),
      .phi2         (phi2),
      .cpu_wdata    (cpu_wdata),
      .cpu_rdata_int(cpu_rdata_int),
      .port_val     (gp_out[N_APORT*PORT_W +: PORT_W]),
      .port_oe      (gp_oe[N_APORT*PORT_W +: PORT_W]),
      .pin_out      (data_pin_out),
      .pin_oe       (data_pin_oe)
   );

   assign take_rd = mode.bus_on & ~onchip_sel & cpu_rnw & phi2;

   xbus_rd_capture #(
      .DATA_W     (PORT_W),
      .CAPTURE_REG(CAPTURE_REG)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take_rd),
      .pin_in(data_pin_in),
      .rdata (ext_rdata)
   );

endmodule

// File: rtl/xbus_port_mux_chk.sv
module xbus_port_mux_chk #(
   parameter int ADDR_W      = 16,
   parameter int PORT_W      = 8,
   parameter int CTL_W       = 8,
   parameter int EN_BIT_A    = 0,
   parameter int EN_BIT_B    = 7,
   parameter int EMU_BIT     = 3,
   parameter bit CAPTURE_REG = 1'b1,
   localparam int GP_W       = (ADDR_W / PORT_W + 1) * PORT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTL_W-1:0]  ctl_bits,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [PORT_W-1:0] cpu_wdata,
   input logic [PORT_W-1:0] cpu_rdata_int,
   input logic              cpu_rnw,
   input logic              onchip_sel,
   input logic              phi2,
   input logic [GP_W-1:0]   gp_out,
   input logic [GP_W-1:0]   gp_oe,
   input logic [PORT_W-1:0] data_pin_in,
   input logic [ADDR_W-1:0] addr_pin_out,
   input logic [ADDR_W-1:0] addr_pin_oe,
   input logic [PORT_W-1:0] data_pin_out,
   input logic [PORT_W-1:0] data_pin_oe,
   input logic [PORT_W-1:0] ext_rdata
);

   logic bus_c, emu_c;
   assign bus_c = ctl_bits[EN_BIT_A] && ctl_bits[EN_BIT_B];
   assign emu_c = ctl_bits[EMU_BIT];

   assert_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_c |-> (addr_pin_out == gp_out[ADDR_W-1:0] && addr_pin_oe == gp_oe[ADDR_W-1:0]));

   assert_addr_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_c |-> addr_pin_oe == '1);

   assert_addr_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_c && !emu_c && onchip_sel) |-> addr_pin_out == '1);

   assert_data_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_c && !emu_c && onchip_sel) |-> (data_pin_out == '1 && data_pin_oe == '1));

   assert_addr_traced_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_c && emu_c) |-> addr_pin_out == cpu_addr);

   assert_float_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_c && !onchip_sel && !phi2) |-> data_pin_oe == '0);

   assert_write_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_c && !onchip_sel && phi2 && !cpu_rnw) |-> (data_pin_out == cpu_wdata && data_pin_oe == '1));

   generate
      if (CAPTURE_REG) begin : g_cap_chk
         assert_read_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_c && !onchip_sel && cpu_rnw && phi2) |=> ext_rdata == $past(data_pin_in));
         assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_c && !onchip_sel && cpu_rnw && phi2) |=> $stable(ext_rdata));
      end
   endgenerate

endmodule

bind xbus_port_mux xbus_port_mux_chk #(
   .ADDR_W     (ADDR_W),
   .PORT_W     (PORT_W),
   .CTL_W      (CTL_W),
   .EN_BIT_A   (EN_BIT_A),
   .EN_BIT_B   (EN_BIT_B),
   .EMU_BIT    (EMU_BIT),
   .CAPTURE_REG(CAPTURE_REG)
) u_chk (.*);

// File: tb/xbus_port_mux_bench.sv
module xbus_port_mux_bench;

   typedef struct {
      logic [15:0] a_out;
      logic [15:0] a_oe;
      logic [7:0]  d_out;
      logic [7:0]  d_oe;
      logic [7:0]  rd;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ctl_bits = '0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata_int = '0;
   logic        cpu_rnw = 1'b1;
   logic        onchip_sel = 1'b0;
   logic        phi2 = 1'b0;
   logic [23:0] gp_out = '0;
   logic [23:0] gp_oe = '0;
   logic [7:0]  data_pin_in = '0;
   logic [15:0] addr_pin_out;
   logic [15:0] addr_pin_oe;
   logic [7:0]  data_pin_out;
   logic [7:0]  data_pin_oe;
   logic [7:0]  ext_rdata;

   int   n_checks = 0;
   int   n_errors = 0;
   logic [7:0] rd_model = '0;
   exp_t sb_q[$];
   bit   stim_done = 1'b0;

   always #10 clk = ~clk;

   xbus_port_mux u_xbus_port_mux (.*);

   function automatic exp_t model(string tag);
      exp_t e;
      logic bus, emu;
      bus = ctl_bits[0] & ctl_bits[7];
      emu = ctl_bits[3];
      e.tag = tag;
      e.rd  = rd_model;
      if (!bus) begin
         e.a_out = gp_out[15:0];  e.a_oe = gp_oe[15:0];
         e.d_out = gp_out[23:16]; e.d_oe = gp_oe[23:16];
      end else if (onchip_sel && !emu) begin
         e.a_out = '1; e.a_oe = '1; e.d_out = '1; e.d_oe = '1;
      end else begin
         e.a_out = cpu_addr; e.a_oe = '1;
         if (onchip_sel) begin
            e.d_out = cpu_rnw ? cpu_rdata_int : cpu_wdata;
            e.d_oe  = '1;
         end else begin
            e.d_out = cpu_wdata;
            e.d_oe  = (phi2 && !cpu_rnw) ? 8'hFF : 8'h00;
         end
      end
      return e;
   endfunction

   task automatic drive(input logic [7:0] ctl, input logic onchip, input logic rnw,
                        input logic ph, input logic [7:0] pin, input string tag);
      exp_t e;
      ctl_bits = ctl; onchip_sel = onchip; cpu_rnw = rnw; phi2 = ph; data_pin_in = pin;
      e = model(tag);
      sb_q.push_back(e);
      @(posedge clk);
      if (rst_n && ctl[0] && ctl[7] && !onchip && rnw && ph) rd_model = pin;
      #2;
   endtask

   task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            cmp(e.tag, "addr_out", addr_pin_out, e.a_out);
            cmp(e.tag, "addr_oe",  addr_pin_oe,  e.a_oe);
            cmp(e.tag, "data_out", {8'h00, data_pin_out}, {8'h00, e.d_out});
            cmp(e.tag, "data_oe",  {8'h00, data_pin_oe},  {8'h00, e.d_oe});
            cmp(e.tag, "rdata",    {8'h00, ext_rdata},    {8'h00, e.rd});
         end
      end
   end

   initial begin : watchdog
      #(20 * 5000);
      if (!stim_done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      @(posedge clk); #2;
      gp_out = 24'hC3_5A_A5; gp_oe = 24'h0F_F0_3C;
      cpu_addr = 16'h12F4; cpu_wdata = 8'h6B; cpu_rdata_int = 8'hD2;
      drive(8'h81, 1'b0, 1'b1, 1'b1, 8'h77, "R10 reset");
      drive(8'h00, 1'b0, 1'b1, 1'b1, 8'h77, "R10 reset");
      rst_n = 1'b1;
      drive(8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R2 port fallback");
      drive(8'h01, 1'b0, 1'b1, 1'b1, 8'h11, "R1 only bit0");
      drive(8'h80, 1'b1, 1'b0, 1'b0, 8'h22, "R1 only bit7");
      gp_out = 24'h96_0F_F0; gp_oe = 24'hF0_AA_55;
      drive(8'h7E, 1'b0, 1'b1, 1'b1, 8'h33, "R2 other bits set");
      drive(8'h81, 1'b1, 1'b1, 1'b1, 8'h44, "R4 R5 onchip read");
      cpu_addr = 16'h8001;
      drive(8'hF7, 1'b1, 1'b0, 1'b0, 8'h44, "R1 R4 R5 padded ctl");
      drive(8'h81, 1'b0, 1'b0, 1'b1, 8'h44, "R3 R9 ext write high");
      drive(8'h81, 1'b0, 1'b0, 1'b0, 8'h44, "R8 ext write low");
      drive(8'h81, 1'b0, 1'b1, 1'b1, 8'h3C, "R10 ext read high");
      drive(8'h81, 1'b0, 1'b1, 1'b0, 8'h99, "R8 R10 ext read low");
      drive(8'h81, 1'b1, 1'b1, 1'b1, 8'hE7, "R10 onchip no capture");
      cpu_addr = 16'hA55A;
      drive(8'h89, 1'b1, 1'b1, 1'b1, 8'h00, "R6 R7 emu onchip read");
      drive(8'h89, 1'b1, 1'b0, 1'b0, 8'h00, "R6 R7 emu onchip write");
      drive(8'h89, 1'b0, 1'b1, 1'b0, 8'h5A, "R6 R8 emu ext read low");
      drive(8'h89, 1'b0, 1'b1, 1'b1, 8'hC1, "R6 R10 emu ext read high");
      drive(8'h08, 1'b0, 1'b1, 1'b1, 8'h18, "R1 emu bit alone");
      drive(8'h00, 1'b0, 1'b1, 1'b1, 8'h18, "R10 hold");
      @(negedge clk); @(negedge clk);
      stim_done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule